// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder/Subtractor

This block adds or subtracts two eight-position operands without any carry chain. The first operand is a signed-digit number whose digits take the values -1, 0 and +1, each carried on two wires. The second operand is an ordinary unsigned binary number. The result is another signed-digit number, and no path through the logic crosses more than two neighbouring positions.

Every position splits its own digit sum or difference into a transfer digit, worth twice the position weight, and an interim digit. All positions do this at the same time. Each result digit then merges its own interim digit with the transfer from the position just below. The ranges of the two parts are chosen so that they never meet on the same wire. The merge therefore needs no arithmetic at all.

A single mode input chooses addition or subtraction. The transfer out of the top position is brought out as a ninth result digit, so the result is always exact. The block is purely combinational and has no clock.

Top module: `hy2_addsub`

## Requirements
- R1: With `mode_sub` = 0, the result value equals X + Y. The result value is sum over i of (s_pos[i] - s_neg[i])·2^i plus (t_out_pos - t_out_neg)·2^8. The value of X is sum over i of (x_pos[i] - x_neg[i])·2^i, and the value of Y is unsigned.
- R2: With `mode_sub` = 1, the result value equals X - Y.
- R3: An X digit with both wires high has the value 0, the same as both wires low.
- R4: In add mode, s_pos[0] = 0 and t_out_neg = 0.
- R5: In subtract mode, s_neg[0] = 0 and t_out_pos = 0.
- R6: Changing the inputs of position j can alter only result digit j and result digit j+1. Result digit 8 is the transfer-out pair.
- R7: For every position i, the interim wire carries the parity of p_i, where p_i = x_i + y_i in add mode and x_i - y_i in subtract mode. The interim wire is s_neg[i] in add mode and s_pos[i] in subtract mode.
- R8: For every position i, the transfer leaving position i lands in digit i+1. In add mode the wire is s_pos[i+1] (or t_out_pos at the top), and it equals (p_i > 0). In subtract mode the wire is s_neg[i+1] (or t_out_neg at the top), and it equals (p_i < 0).
- R9: The extreme results +510 and -510 are represented exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_sub | input | 1 | 0 adds, 1 subtracts |
| x_pos | input | 8 | Positive wires of the signed-digit operand |
| x_neg | input | 8 | Negative wires of the signed-digit operand |
| y | input | 8 | Unsigned binary operand |
| s_pos | output | 8 | Positive wires of result digits 0..7 |
| s_neg | output | 8 | Negative wires of result digits 0..7 |
| t_out_pos | output | 1 | Positive wire of result digit 8 |
| t_out_neg | output | 1 | Negative wire of result digit 8 |

## Verification
There is no stored state, so a wrong transfer or interim bit at position i shows up at the ports as soon as the inputs settle. It appears in result digit i or i+1 and moves the total value by exactly a power of two. The per-position parity and transfer checks point to the faulty position. The value check catches any swap between the add and subtract decompositions. The locality check catches any logic that reaches further than one neighbouring position.

// File: rtl/hy2_pkg.sv
package hy2_pkg;

    // One signed digit: value = pos - neg
    typedef struct packed {
        logic pos;
        logic neg;
    } sdig_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    localparam sdig_t SD_ZERO = '{pos: 1'b0, neg: 1'b0};

    function automatic logic sd_plus(input sdig_t d);
        return d.pos & ~d.neg;
    endfunction

    function automatic logic sd_minus(input sdig_t d);
        return d.neg & ~d.pos;
    endfunction

endpackage

// File: rtl/hy2_split.sv
module hy2_split
    import hy2_pkg::*;
(
    input  sdig_t xd,
    input  logic  yb,
    input  op_e   op,
    output sdig_t xfer,
    output sdig_t interim
);
    logic is_p1, is_m1, odd, above, below;

    always_comb begin
        is_p1 = sd_plus(xd);
        is_m1 = sd_minus(xd);
        odd   = (is_p1 | is_m1) ^ yb;
        // sum x+y positive: x=+1, or y=1 while x is not -1
        above = is_p1 | (yb & ~is_m1);
        // difference x-y negative: x=-1, or y=1 while x is not +1
        below = is_m1 | (yb & ~is_p1);
        xfer    = SD_ZERO;
        interim = SD_ZERO;
        if (op == OP_ADD) begin
            xfer.pos    = above;
            interim.neg = odd;
        end else begin
            xfer.neg    = below;
            interim.pos = odd;
        end
    end
endmodule

// File: rtl/hy2_merge.sv
module hy2_merge
    import hy2_pkg::*;
(
    input  sdig_t interim,
    input  sdig_t xfer_in,
    output sdig_t sd
);
    // The two parts never share a wire, so a plain OR merges them
    always_comb begin
        sd.pos = interim.pos | xfer_in.pos;
        sd.neg = interim.neg | xfer_in.neg;
    end
endmodule

// File: rtl/hy2_addsub.sv
module hy2_addsub
    import hy2_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic              mode_sub,
    input  logic [DIGITS-1:0] x_pos,
    input  logic [DIGITS-1:0] x_neg,
    input  logic [DIGITS-1:0] y,
    output logic [DIGITS-1:0] s_pos,
    output logic [DIGITS-1:0] s_neg,
    output logic              t_out_pos,
    output logic              t_out_neg
);
    localparam int TOP = DIGITS - 1;

    op_e                op;
    sdig_t [DIGITS-1:0] xfer;
    sdig_t [DIGITS-1:0] interim;
    sdig_t [DIGITS-1:0] xfer_in;
    sdig_t [DIGITS-1:0] res;

    assign op = op_e'(mode_sub);

    for (genvar i = 0; i < DIGITS; i++) begin : g_pos
        sdig_t xd;
        assign xd = '{pos: x_pos[i], neg: x_neg[i]};

        hy2_split u_split (
            .xd      (xd),
            .yb      (y[i]),
            .op      (op),
            .xfer    (xfer[i]),
            .interim (interim[i])
        );

        if (i == 0) begin : g_lsd
            assign xfer_in[i] = SD_ZERO;
        end else begin : g_up
            assign xfer_in[i] = xfer[i-1];
        end

        hy2_merge u_merge (
            .interim (interim[i]),
            .xfer_in (xfer_in[i]),
            .sd      (res[i])
        );

        assign s_pos[i] = res[i].pos;
        assign s_neg[i] = res[i].neg;
    end

    assign t_out_pos = xfer[TOP].pos;
    assign t_out_neg = xfer[TOP].neg;
endmodule

// File: rtl/hy2_addsub_chk.sv
module hy2_addsub_chk #(
    parameter int DIGITS = 8
) (
    input logic              mode_sub,
    input logic [DIGITS-1:0] x_pos,
    input logic [DIGITS-1:0] x_neg,
    input logic [DIGITS-1:0] y,
    input logic [DIGITS-1:0] s_pos,
    input logic [DIGITS-1:0] s_neg,
    input logic              t_out_pos,
    input logic              t_out_neg
);
    logic known;
    int   xval, yval, sval, want;

    assign known = !$isunknown({mode_sub, x_pos, x_neg, y, s_pos, s_neg, t_out_pos, t_out_neg});

    always_comb begin
        xval = 0;
        yval = 0;
        sval = 0;
        for (int i = 0; i < DIGITS; i++) begin
            xval += (int'(x_pos[i]) - int'(x_neg[i])) * (1 << i);
            yval += int'(y[i]) * (1 << i);
            sval += (int'(s_pos[i]) - int'(s_neg[i])) * (1 << i);
        end
        sval += (int'(t_out_pos) - int'(t_out_neg)) * (1 << DIGITS);
        want = mode_sub ? (xval - yval) : (xval + yval);
    end

    always_comb begin
        if (known) begin
            p_value_r1_r2: assert (sval == want);
            if (!mode_sub) begin
                p_add_wires_r4: assert (!s_pos[0] && !t_out_neg);
            end else begin
                p_sub_wires_r5: assert (!s_neg[0] && !t_out_pos);
            end
            for (int i = 0; i < DIGITS; i++) begin
                int  p;
                logic up;
                p  = int'(x_pos[i]) - int'(x_neg[i]) + (mode_sub ? -int'(y[i]) : int'(y[i]));
                up = (i == DIGITS - 1) ? (mode_sub ? t_out_neg : t_out_pos)
                                       : (mode_sub ? s_neg[(i+1) % DIGITS] : s_pos[(i+1) % DIGITS]);
                p_parity_r7: assert ((mode_sub ? s_pos[i] : s_neg[i]) == p[0]);
                p_transfer_r8: assert (up == (mode_sub ? (p < 0) : (p > 0)));
            end
        end
    end
endmodule

bind hy2_addsub hy2_addsub_chk #(.DIGITS(DIGITS)) u_chk (
    .mode_sub  (mode_sub),
    .x_pos     (x_pos),
    .x_neg     (x_neg),
    .y         (y),
    .s_pos     (s_pos),
    .s_neg     (s_neg),
    .t_out_pos (t_out_pos),
    .t_out_neg (t_out_neg)
);

// File: tb/sim_hy2_addsub.sv
module sim_hy2_addsub;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         mode_sub;
    logic [N-1:0] x_pos, x_neg, y;
    logic [N-1:0] s_pos, s_neg;
    logic         t_out_pos, t_out_neg;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hy2_addsub #(.DIGITS(N)) u0 (
        .mode_sub (mode_sub),
        .x_pos    (x_pos),
        .x_neg    (x_neg),
        .y        (y),
        .s_pos    (s_pos),
        .s_neg    (s_neg),
        .t_out_pos(t_out_pos),
        .t_out_neg(t_out_neg)
    );

    function automatic int x_value(input logic [N-1:0] p, input logic [N-1:0] n);
        int v = 0;
        for (int i = 0; i < N; i++) v += (int'(p[i]) - int'(n[i])) * (1 << i);
        return v;
    endfunction

    function automatic int res_value();
        int v = x_value(s_pos, s_neg);
        v += (int'(t_out_pos) - int'(t_out_neg)) * (1 << N);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic m, input logic [N-1:0] xp, input logic [N-1:0] xn,
                         input logic [N-1:0] yy);
        @(negedge clk);
        mode_sub = m;
        x_pos    = xp;
        x_neg    = xn;
        y        = yy;
        @(posedge clk);
        #1;
    endtask

    // value, wire usage, per-digit parity and transfer checks
    task automatic check_all();
        int xv  = x_value(x_pos, x_neg);
        int yv  = int'(y);
        int exp = mode_sub ? xv - yv : xv + yv;
        int act = res_value();
        int badp = 0;
        int badt = 0;
        check(act == exp, mode_sub ? "R2 difference value" : "R1 sum value", act, exp);
        if (!mode_sub)
            check(!s_pos[0] && !t_out_neg, "R4 add-mode idle wires", {s_pos[0], t_out_neg}, 0);
        else
            check(!s_neg[0] && !t_out_pos, "R5 sub-mode idle wires", {s_neg[0], t_out_pos}, 0);
        for (int i = 0; i < N; i++) begin
            int   p = int'(x_pos[i]) - int'(x_neg[i]) + (mode_sub ? -int'(y[i]) : int'(y[i]));
            logic iw = mode_sub ? s_pos[i] : s_neg[i];
            logic tw;
            if (i == N-1) tw = mode_sub ? t_out_neg : t_out_pos;
            else          tw = mode_sub ? s_neg[i+1] : s_pos[i+1];
            if (iw != p[0]) badp++;
            if (tw != (mode_sub ? (p < 0) : (p > 0))) badt++;
        end
        check(badp == 0, "R7 interim parity", badp, 0);
        check(badt == 0, "R8 transfer wires", badt, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] bp, bn, by, xp2, xn2;
        logic [N-1:0] ref_p, ref_n;
        logic         ref_tp, ref_tn;
        void'($urandom(32'h5EED_0042));

        // all-zero inputs give an all-zero result
        apply(1'b0, '0, '0, '0);
        check(s_pos == 0 && s_neg == 0 && !t_out_pos && !t_out_neg,
              "R1 zero inputs", {s_pos, s_neg}, 0);

        // R9 extremes
        apply(1'b0, '1, '0, '1);
        check(res_value() == 510, "R9 max sum", res_value(), 510);
        check_all();
        apply(1'b1, '0, '1, '1);
        check(res_value() == -510, "R9 min difference", res_value(), -510);
        check_all();

        // R3: (1,1) digits behave as zero
        for (int k = 0; k < 50; k++) begin
            int   v0;
            logic m = 1'($urandom);
            bp = N'($urandom); bn = N'($urandom); by = N'($urandom);
            apply(m, bp & ~bn, bn & ~bp, by);
            v0 = res_value();
            apply(m, bp, bn, by);
            check(res_value() == v0, "R3 both-high digit is zero", res_value(), v0);
        end

        // exhaustive low four positions, both modes
        for (int m = 0; m < 2; m++)
            for (int code = 0; code < 81; code++)
                for (int yy = 0; yy < 16; yy++) begin
                    int c = code;
                    xp2 = '0; xn2 = '0;
                    for (int i = 0; i < 4; i++) begin
                        if (c % 3 == 1) xp2[i] = 1'b1;
                        if (c % 3 == 2) xn2[i] = 1'b1;
                        c = c / 3;
                    end
                    apply(m[0], xp2, xn2, N'(yy));
                    check_all();
                end

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            bp = N'($urandom); bn = N'($urandom);
            apply(1'($urandom), bp, bn & ~bp, N'($urandom));
            check_all();
        end

        // R6 locality: flip one position, only digits j and j+1 may move
        for (int k = 0; k < 400; k++) begin
            int   j = $urandom_range(N-1, 0);
            logic m = 1'($urandom);
            logic [N-1:0] keep;
            bp = N'($urandom); bn = N'($urandom) & ~bp; by = N'($urandom);
            apply(m, bp, bn, by);
            ref_p = s_pos; ref_n = s_neg; ref_tp = t_out_pos; ref_tn = t_out_neg;
            by[j] = ~by[j];
            if ($urandom_range(1, 0) == 1) begin
                bp[j] = ~bp[j]; bn[j] = 1'b0;
            end
            apply(m, bp, bn, by);
            keep = '1;
            keep[j] = 1'b0;
            if (j < N-1) keep[j+1] = 1'b0;
            check(((s_pos ^ ref_p) & keep) == 0 && ((s_neg ^ ref_n) & keep) == 0 &&
                  (j == N-1 || (t_out_pos == ref_tp && t_out_neg == ref_tn)),
                  "R6 locality", int'((s_pos ^ ref_p) & keep), 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule